// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Sequencer

This block sits on the controller side of an asynchronous DRAM and keeps every row refreshed. A free-running interval timer adds one owed refresh every `REF_INTERVAL` clock cycles. The sequencer pays each owed refresh with a CAS-before-RAS cycle, so it never drives a row address because the memory's own row counter chooses the row. Host accesses go through a request/grant handshake. A refresh that falls due while the host holds the grant waits until the host drops its request. The sequencer then pays the whole backlog back to back before it grants again. A saturating backlog counter raises a sticky error flag when the owed count goes above `OWE_LIMIT`.

A sleep request starts a CBR cycle and keeps both strobes low, which puts the memory in self-refresh. RAS# stays low for at least `T_RASS` cycles, even if the sleep request drops earlier. After RAS# rises, all strobes stay high for at least `T_RPS` cycles. While the block is not ready, the interval timer is frozen, because the memory refreshes itself during that time. The recovery after exit depends on a mode input. In distributed style the block becomes ready as soon as the exit precharge ends. In burst style it first runs `ROWS` CBR cycles back to back, then clears the backlog and becomes ready. All timings are clock-cycle counts fixed at elaboration.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held and just after it is released, `ras_n`, `cas_n` and `we_n` are 1, `host_gnt` is 0, `self_refresh` is 0, `ready` is 1 and `owe_err` is 0.
- R2: In every refresh cycle the following holds:
  - `cas_n` is 0 for exactly `T_CSR` cycles with `ras_n` at 1 before `ras_n` falls.
  - In a normal refresh, `ras_n` stays 0 for exactly `T_RAS` cycles.
  - Both strobes rise in the same cycle.
  - Both strobes then stay at 1 for at least `T_RP` cycles before `cas_n` falls again.
  - `we_n` is always 1.
- R3: Starting from reset, one refresh falls due every `REF_INTERVAL` cycles. With no host traffic, each one is issued at once, so K intervals produce K refresh cycles.
- R4: When the block is idle and nothing is owed, a `host_req` taken in one cycle gives `host_gnt` = 1 in the next cycle. The grant holds while `host_req` stays 1. During a grant both strobes stay at 1.
- R5: While any refresh is owed, no new grant is given. Refreshes that fell due during a grant run back to back once `host_req` drops, and only then is the grant given again.
- R6: The owed count saturates at `OWE_LIMIT`+1. `owe_err` goes to 1 once the count goes above `OWE_LIMIT`, and only reset clears it. A count equal to `OWE_LIMIT` leaves `owe_err` at 0.
- R7: `sleep_req` = 1 in the idle state starts a CBR cycle and then keeps both strobes at 0. `self_refresh` is 1 during that hold, and no grant is given.
- R8: In self-refresh, `ras_n` stays at 0 for at least `T_RASS` cycles. It rises at the later of that minimum and `sleep_req` returning to 0.
- R9: After self-refresh ends, all strobes stay at 1 for at least `T_RPS` cycles. No refreshes are owed for the time spent in self-refresh.
- R10: With `burst_mode` = 0 (distributed style), `ready` returns to 1 exactly `T_RPS` cycles after `ras_n` rises, and no refresh cycles are run.
- R11: With `burst_mode` = 1 (burst style), exactly `ROWS` CBR cycles run back to back after the exit precharge. `ready` returns to 1 exactly `T_RPS` + `ROWS`×(`T_CSR`+`T_RAS`+`T_RP`) cycles after `ras_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| burst_mode | input | 1 | Recovery style after self-refresh: 1 burst, 0 distributed |
| sleep_req | input | 1 | Level request to enter and stay in self-refresh |
| host_req | input | 1 | Host access request, held for the whole host cycle |
| host_gnt | output | 1 | Host access granted |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low, held inactive |
| self_refresh | output | 1 | Memory is held in self-refresh |
| ready | output | 1 | Normal accesses may proceed |
| owe_err | output | 1 | Sticky flag: owed refreshes went above the limit |

## Verification
The bench uses a small configuration with 8 rows and a 64-cycle interval.

Refresh scheduling is tried in three ways:
- With an idle host, the refresh count must match the elapsed intervals exactly.
- With a grant held across exactly three intervals, three refreshes must follow back to back before the next grant. This sits at the error limit, so it separates the boundary from an overflow.
- With a grant held across five intervals, only four refreshes must follow, which shows the counter saturating.

Self-refresh is tried three times:
- A short sleep, which separates the `T_RASS` minimum from the sleep level.
- A long sleep with the host waiting, which shows that no refreshes were owed for the sleep time.
- A burst-style exit, where the cycle count and the exact time `ready` returns separate the two recovery styles.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOST,
    ST_CSR,
    ST_RAS,
    ST_PRE,
    ST_SRHOLD,
    ST_SREXIT
  } ref_state_t;

  typedef enum logic [1:0] {
    K_NORM,
    K_SR,
    K_BURST
  } cyc_kind_t;

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int REF_INTERVAL = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int TW = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;
  localparam logic [TW-1:0] LAST = TW'(REF_INTERVAL - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = en && (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/owe_counter.sv
module owe_counter #(
  parameter int OWE_LIMIT = 8,
  parameter int OWE_W     = $clog2(OWE_LIMIT + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  input  logic             clr,
  output logic [OWE_W-1:0] owed,
  output logic             pending,
  output logic             err
);
  localparam logic [OWE_W-1:0] SAT = OWE_W'(OWE_LIMIT + 1);
  localparam logic [OWE_W-1:0] LIM = OWE_W'(OWE_LIMIT);

  logic [OWE_W-1:0] cnt_d;
  logic             err_d;
  logic             upd;

  always_comb begin
    cnt_d = owed;
    if (clr) begin
      cnt_d = '0;
    end else if (inc && !dec) begin
      cnt_d = (owed == SAT) ? SAT : owed + 1'b1;
    end else if (dec && !inc && owed != '0) begin
      cnt_d = owed - 1'b1;
    end
    err_d   = err || (cnt_d > LIM);
    upd     = inc || dec || clr;
    pending = (owed != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed <= '0;
      err  <= 1'b0;
    end else if (upd) begin
      owed <= cnt_d;
      err  <= err_d;
    end
  end
endmodule

// File: rtl/ref_fsm.sv
module ref_fsm
  import dram_ref_pkg::*;
#(
  parameter int ROWS   = 1024,
  parameter int T_CSR  = 2,
  parameter int T_RAS  = 6,
  parameter int T_RP   = 4,
  parameter int T_RASS = 100,
  parameter int T_RPS  = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic burst_mode,
  input  logic sleep_req,
  input  logic host_req,
  input  logic pending,
  output logic launch,
  output logic flush,
  output logic host_gnt,
  output logic ras_n,
  output logic cas_n,
  output logic self_refresh,
  output logic ready
);
  localparam int TA    = (T_CSR > T_RAS) ? T_CSR : T_RAS;
  localparam int TB    = (T_RP > T_RASS) ? T_RP : T_RASS;
  localparam int TC    = (TA > TB) ? TA : TB;
  localparam int T_MAX = (TC > T_RPS) ? TC : T_RPS;
  localparam int TW    = $clog2(T_MAX + 1);
  localparam int BW    = (ROWS > 2) ? $clog2(ROWS) : 1;

  localparam logic [TW-1:0] LD_CSR  = TW'(T_CSR - 1);
  localparam logic [TW-1:0] LD_RAS  = TW'(T_RAS - 1);
  localparam logic [TW-1:0] LD_RP   = TW'(T_RP - 1);
  localparam logic [TW-1:0] LD_RASS = TW'(T_RASS - 1);
  localparam logic [TW-1:0] LD_RPS  = TW'(T_RPS - 1);
  localparam logic [BW-1:0] LD_ROWS = BW'(ROWS - 1);

  ref_state_t      state_q, state_d;
  cyc_kind_t       kind_q, kind_d;
  logic [TW-1:0]   cnt_q, cnt_d;
  logic [BW-1:0]   left_q, left_d;
  logic            ready_d;
  logic            left_en;
  logic            cnt_zero;

  always_comb begin
    state_d  = state_q;
    kind_d   = kind_q;
    cnt_zero = (cnt_q == '0);
    cnt_d    = cnt_zero ? cnt_q : cnt_q - 1'b1;
    left_d   = left_q;
    left_en  = 1'b0;
    ready_d  = ready;
    launch   = 1'b0;
    flush    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (sleep_req) begin
          state_d = ST_CSR;
          kind_d  = K_SR;
          cnt_d   = LD_CSR;
          ready_d = 1'b0;
        end else if (pending) begin
          state_d = ST_CSR;
          kind_d  = K_NORM;
          cnt_d   = LD_CSR;
          launch  = 1'b1;
        end else if (host_req) begin
          state_d = ST_HOST;
        end
      end
      ST_HOST: begin
        if (!host_req) state_d = ST_IDLE;
      end
      ST_CSR: begin
        if (cnt_zero) begin
          state_d = (kind_q == K_SR) ? ST_SRHOLD : ST_RAS;
          cnt_d   = (kind_q == K_SR) ? LD_RASS : LD_RAS;
        end
      end
      ST_RAS: begin
        if (cnt_zero) begin
          state_d = ST_PRE;
          cnt_d   = LD_RP;
        end
      end
      ST_PRE: begin
        if (cnt_zero) begin
          if (kind_q == K_BURST && left_q != '0) begin
            state_d = ST_CSR;
            cnt_d   = LD_CSR;
            left_d  = left_q - 1'b1;
            left_en = 1'b1;
          end else if (kind_q == K_BURST) begin
            state_d = ST_IDLE;
            kind_d  = K_NORM;
            ready_d = 1'b1;
            flush   = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_SRHOLD: begin
        if (cnt_zero && !sleep_req) begin
          state_d = ST_SREXIT;
          cnt_d   = LD_RPS;
        end
      end
      ST_SREXIT: begin
        if (cnt_zero) begin
          if (burst_mode) begin
            state_d = ST_CSR;
            kind_d  = K_BURST;
            cnt_d   = LD_CSR;
            left_d  = LD_ROWS;
            left_en = 1'b1;
          end else begin
            state_d = ST_IDLE;
            kind_d  = K_NORM;
            ready_d = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= K_NORM;
      cnt_q   <= '0;
      ready   <= 1'b1;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      cnt_q   <= cnt_d;
      ready   <= ready_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (left_en) begin
      left_q <= left_d;
    end
  end

  always_comb begin
    host_gnt     = (state_q == ST_HOST);
    self_refresh = (state_q == ST_SRHOLD);
    cas_n        = !(state_q == ST_CSR || state_q == ST_RAS || state_q == ST_SRHOLD);
    ras_n        = !(state_q == ST_RAS || state_q == ST_SRHOLD);
  end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int ROWS         = 1024,
  parameter int REF_INTERVAL = 1000,
  parameter int T_CSR        = 2,
  parameter int T_RAS        = 6,
  parameter int T_RP         = 4,
  parameter int T_RASS       = 100,
  parameter int T_RPS        = 12,
  parameter int OWE_LIMIT    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic burst_mode,
  input  logic sleep_req,
  input  logic host_req,
  output logic host_gnt,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic self_refresh,
  output logic ready,
  output logic owe_err
);
  localparam int OWE_W = $clog2(OWE_LIMIT + 2);

  logic [1:0]       rs_q;
  logic             rst_sync_n;
  logic             tick;
  logic             launch;
  logic             flush;
  logic             pending;
  logic [OWE_W-1:0] owed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rs_q[1];

  ref_interval_timer #(.REF_INTERVAL(REF_INTERVAL)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (ready),
    .tick  (tick)
  );

  owe_counter #(.OWE_LIMIT(OWE_LIMIT), .OWE_W(OWE_W)) u_owe (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .inc     (tick),
    .dec     (launch),
    .clr     (flush),
    .owed    (owed),
    .pending (pending),
    .err     (owe_err)
  );

  ref_fsm #(
    .ROWS   (ROWS),
    .T_CSR  (T_CSR),
    .T_RAS  (T_RAS),
    .T_RP   (T_RP),
    .T_RASS (T_RASS),
    .T_RPS  (T_RPS)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .burst_mode   (burst_mode),
    .sleep_req    (sleep_req),
    .host_req     (host_req),
    .pending      (pending),
    .launch       (launch),
    .flush        (flush),
    .host_gnt     (host_gnt),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .self_refresh (self_refresh),
    .ready        (ready)
  );

  assign we_n = 1'b1;
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int OWE_LIMIT = 8,
  parameter int OWE_W     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             host_gnt,
  input logic             self_refresh,
  input logic             ready,
  input logic             owe_err,
  input logic [OWE_W-1:0] owed
);
  // R2: CAS# is already low in the cycle before RAS# falls
  assert_cas_leads_ras_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n));

  // R2: both strobes return high together
  assert_strobes_rise_together_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_n);

  // R4: strobes stay idle while the host owns the memory
  assert_grant_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    host_gnt |-> (ras_n && cas_n));

  // R5: a new grant only follows a clear backlog
  assert_grant_only_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_gnt) |-> $past(owed == '0));

  // R6: backlog never passes saturation
  assert_owed_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= OWE_W'(OWE_LIMIT + 1));

  // R6: error flag is sticky
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    owe_err |=> owe_err);

  // R7: self-refresh holds both strobes and excludes the host
  assert_sr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    self_refresh |-> (!host_gnt && !ras_n && !cas_n && !ready));

  // R10: readiness only returns with strobes idle
  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (ras_n && cas_n));
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
  .OWE_LIMIT (OWE_LIMIT),
  .OWE_W     (OWE_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .ras_n        (ras_n),
  .cas_n        (cas_n),
  .host_gnt     (host_gnt),
  .self_refresh (self_refresh),
  .ready        (ready),
  .owe_err      (owe_err),
  .owed         (owed)
);

// File: tb/dram_refresh_seq_test.sv
`timescale 1ns/1ps
module dram_refresh_seq_test;
  localparam int ROWS = 8;
  localparam int RI   = 64;
  localparam int TCSR = 2;
  localparam int TRAS = 4;
  localparam int TRP  = 3;
  localparam int TRASS = 10;
  localparam int TRPS = 5;
  localparam int LIM  = 3;

  logic clk = 1'b0;
  logic rst_n, burst_mode, sleep_req, host_req;
  logic host_gnt, ras_n, cas_n, we_n, self_refresh, ready, owe_err;

  always #5 clk = ~clk;

  dram_refresh_seq #(
    .ROWS(ROWS), .REF_INTERVAL(RI), .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP),
    .T_RASS(TRASS), .T_RPS(TRPS), .OWE_LIMIT(LIM)
  ) uut (
    .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .sleep_req(sleep_req),
    .host_req(host_req), .host_gnt(host_gnt), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .self_refresh(self_refresh), .ready(ready), .owe_err(owe_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int falls = 0;
  int setup_len = 0, ras_len = 0, high_len = 1000;
  int last_sr_w = 0, sr_rise_cyc = 0;
  bit sr_seen = 0, last_sr = 0, mon_en = 0;
  logic p_ras = 1'b1, p_cas = 1'b1;
  int wd = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // strobe monitor: shapes of every cycle
  always @(negedge clk) begin
    if (mon_en) begin
      cyc++;
      chk(we_n == 1'b1, "R2 we_n held high", int'(we_n), 1);
      if (host_gnt) chk(ras_n && cas_n, "R4 strobes idle during grant", int'(ras_n && cas_n), 1);
      if (self_refresh) begin
        chk(!host_gnt, "R7 no grant in self refresh", int'(host_gnt), 0);
        sr_seen = 1;
      end
      if (p_cas && !cas_n) begin
        if (last_sr) chk(high_len >= TRPS, "R9 exit precharge", high_len, TRPS);
        else         chk(high_len >= TRP, "R2 precharge", high_len, TRP);
        high_len = 0;
      end
      if (p_ras && !ras_n) begin
        chk(setup_len == TCSR, "R2 CAS-to-RAS setup", setup_len, TCSR);
        falls++;
      end
      if (!p_ras && ras_n) begin
        chk(cas_n == 1'b1, "R2 CAS rises with RAS", int'(cas_n), 1);
        if (sr_seen) begin
          chk(ras_len >= TRASS, "R8 self refresh min low", ras_len, TRASS);
          last_sr_w   = ras_len;
          last_sr     = 1;
          sr_rise_cyc = cyc;
        end else begin
          chk(ras_len == TRAS, "R2 RAS width", ras_len, TRAS);
          last_sr = 0;
        end
        sr_seen  = 0;
        high_len = 0;
      end
      if (!cas_n && ras_n) setup_len = p_cas ? 1 : setup_len + 1;
      if (!ras_n) ras_len = p_ras ? 1 : ras_len + 1;
      if (ras_n && cas_n) high_len++;
      p_ras = ras_n;
      p_cas = cas_n;
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      finish_run();
    end
  end

  task automatic do_reset();
    mon_en = 0;
    rst_n = 1'b0;
    repeat (3) step();
    chk(ras_n && cas_n && we_n, "R1 strobes high in reset", int'(ras_n && cas_n && we_n), 1);
    chk(!host_gnt && !self_refresh, "R1 no grant or sleep in reset", int'(host_gnt || self_refresh), 0);
    chk(ready && !owe_err, "R1 ready set, error clear", int'(ready && !owe_err), 1);
    rst_n = 1'b1;
    p_ras = 1'b1; p_cas = 1'b1;
    setup_len = 0; ras_len = 0; high_len = 1000;
    sr_seen = 0; last_sr = 0; cyc = 0;
    mon_en = 1;
    step();
    chk(ras_n && cas_n && ready && !owe_err && !host_gnt, "R1 state after release",
        int'(ras_n && cas_n && ready && !owe_err && !host_gnt), 1);
  endtask

  task automatic wait_refresh_done();
    int f;
    f = falls;
    while (falls == f) step();
    while (!ras_n) step();
  endtask

  initial begin
    int f;
    bit early;
    burst_mode = 1'b0; sleep_req = 1'b0; host_req = 1'b0;
    do_reset();

    // R3: idle host, refresh count tracks intervals
    f = falls;
    repeat (10 * RI + 32) step();
    chk(falls - f == 10, "R3 refreshes over ten intervals", falls - f, 10);

    // R4: grant one cycle after request
    wait_refresh_done();
    repeat (5) step();
    host_req = 1'b1;
    step();
    chk(host_gnt == 1'b1, "R4 grant after one cycle", int'(host_gnt), 1);
    repeat (3 * RI) step();
    chk(host_gnt == 1'b1, "R4 grant held", int'(host_gnt), 1);

    // R5: three owed refreshes paid before the next grant
    host_req = 1'b0;
    step();
    host_req = 1'b1;
    f = falls;
    early = 0;
    for (int i = 0; i < 40; i++) begin
      step();
      if (host_gnt && (falls - f) < 3) early = 1;
    end
    chk(!early, "R5 grant withheld while owed", int'(early), 0);
    chk(falls - f == 3, "R5 backlog paid back to back", falls - f, 3);
    chk(host_gnt == 1'b1, "R5 grant after backlog", int'(host_gnt), 1);
    chk(owe_err == 1'b0, "R6 count at limit is no error", int'(owe_err), 0);

    // R6: overflow saturates and flags
    host_req = 1'b0;
    wait_refresh_done();
    repeat (5) step();
    host_req = 1'b1;
    step();
    repeat (5 * RI) step();
    chk(owe_err == 1'b1, "R6 error over limit", int'(owe_err), 1);
    host_req = 1'b0;
    f = falls;
    repeat (45) step();
    chk(falls - f == LIM + 1, "R6 saturated backlog", falls - f, LIM + 1);
    chk(owe_err == 1'b1, "R6 error sticky", int'(owe_err), 1);

    do_reset();

    // R7, R8, R10: short sleep, distributed exit
    wait_refresh_done();
    repeat (5) step();
    sleep_req = 1'b1;
    f = falls;
    repeat (4) step();
    chk(self_refresh == 1'b1, "R7 self refresh entered", int'(self_refresh), 1);
    chk(falls - f == 1 && !ras_n && !cas_n, "R7 strobes held low", int'(ras_n || cas_n), 0);
    sleep_req = 1'b0;
    while (!ras_n) step();
    chk(last_sr_w == TRASS, "R8 RAS low for minimum only", last_sr_w, TRASS);
    while (!ready) step();
    chk(cyc - sr_rise_cyc == TRPS, "R10 ready after exit precharge", cyc - sr_rise_cyc, TRPS);
    f = falls;
    repeat (20) step();
    chk(falls == f, "R10 no burst in distributed style", falls - f, 0);

    // R9: long sleep with host waiting owes nothing
    sleep_req = 1'b1;
    host_req = 1'b1;
    repeat (5 * RI) step();
    chk(host_gnt == 1'b0, "R7 host held off during sleep", int'(host_gnt), 0);
    sleep_req = 1'b0;
    while (!ras_n) step();
    chk(last_sr_w > 5 * RI - 10, "R8 RAS follows sleep level", last_sr_w, 5 * RI);
    while (!ready) step();
    step();
    chk(host_gnt == 1'b1, "R9 no refreshes owed after sleep", int'(host_gnt), 1);
    chk(owe_err == 1'b0, "R9 no error after long sleep", int'(owe_err), 0);
    host_req = 1'b0;
    repeat (3) step();

    // R11: burst-style exit
    burst_mode = 1'b1;
    sleep_req = 1'b1;
    repeat (4) step();
    sleep_req = 1'b0;
    while (!ras_n) step();
    f = falls;
    while (!ready) step();
    chk(falls - f == ROWS, "R11 burst refresh count", falls - f, ROWS);
    chk(cyc - sr_rise_cyc == TRPS + ROWS * (TCSR + TRAS + TRP), "R11 ready timing",
        cyc - sr_rise_cyc, TRPS + ROWS * (TCSR + TRAS + TRP));
    repeat (10) step();

    finish_run();
  end
endmodule